// File: doc/BRIEF.md
# SDRAM Configuration Register with CAS Latency Lock

This block is the single memory-mapped configuration word that an SDRAM controller reads its geometry and CAS latency from. A plain register bus writes it and reads it back. The bus carries an address, a write strobe, byte enables and write data, and read data comes back combinationally. The block stores three small codes: the CAS latency, the internal bank count and the page size. From the stored codes it also drives registered outputs for the bank-address width and the column-address width.

A software write to any configuration byte raises a one-cycle initialization request. The controller uses this pulse to restart its SDRAM power-up sequence. The CAS latency field is guarded: it changes only when the same write also sets a companion key bit. That key bit is never stored. A field written with a reserved code keeps its previous legal value, so the decoded outputs are always valid.

Top module: `sdcfg_reg`

## Requirements
- R1: After reset, the CAS latency code is 3, the bank code is 2 and the page code is 1. The readback value is 0x00000621, `bank_aw` is 2, `col_aw` is 9, and `init_req` stays low with no pulse.
- R2: The CAS latency field in bits 11:9 is loaded only when an accepted write has byte enable 1 set and write data bit 8 set to 1. Without both, the field keeps its value.
- R3: Bit 8 is never stored and always reads back as 0.
- R4: Bits 7, 3 and 31:12 always read as 0, whatever was written to them.
- R5: The bank field in bits 6:4 accepts codes 0, 1 and 2, meaning 1, 2 and 4 banks. A write of codes 3 to 7 leaves the field unchanged.
- R6: The page field in bits 2:0 accepts codes 0 to 3, meaning 8 to 11 column bits. A write of codes 4 to 7 leaves the field unchanged.
- R7: Only CAS latency codes 2 and 3 are accepted. Codes 0, 1 and 4 to 7 leave the field unchanged, even when the key bit is set.
- R8: An accepted write with byte enable 0 or byte enable 1 set raises `init_req` for exactly one cycle. The pulse starts at the same clock edge that updates the fields. It fires even if the written value equals the stored value or carries reserved codes.
- R9: The bank and page fields update only when byte enable 0 is set. A write that enables only bytes 3:2 changes nothing and raises no pulse.
- R10: `bank_aw` equals the stored bank code and `col_aw` equals 8 plus the stored page code. Both are registered and change only at the edge of an accepted write.
- R11: A write to any address other than `REG_ADDR` changes nothing and raises no pulse. A read at another address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_be | input | DATA_W/8 | Byte enables for the write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; the configuration word when the address matches, otherwise 0 |
| cas_lat | output | 3 | Stored CAS latency in clock cycles |
| bank_aw | output | 2 | Bank address width: 0, 1 or 2 |
| col_aw | output | 4 | Column address width: 8 to 11 |
| init_req | output | 1 | One-cycle initialization request |

## Verification
A wrong stored code appears at the ports in the cycle right after the write that caused it. It shows both in the readback word and in the registered width outputs. A gating error on the key bit or a byte enable leaves a stale or wrongly updated field, and the next readback exposes it. A missing, doubled or spurious `init_req` pulse shows up in the cycle after the write, or in the idle cycle that follows it. The sweeps cover every code of every field under each byte-enable and key combination, so a bad legality rule is seen on the first affected code.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;

  typedef logic [2:0] code3_t;

  localparam int CL_LSB   = 9;
  localparam int KEY_BIT  = 8;
  localparam int BANK_LSB = 4;
  localparam int PAGE_LSB = 0;
  localparam int CFG_W    = 12;

  localparam code3_t CL_RST   = 3'd3;
  localparam code3_t BANK_RST = 3'd2;
  localparam code3_t PAGE_RST = 3'd1;

  function automatic logic cl_legal(code3_t c);
    return (c == 3'd2) || (c == 3'd3);
  endfunction

  function automatic logic bank_legal(code3_t c);
    return c <= 3'd2;
  endfunction

  function automatic logic page_legal(code3_t c);
    return c <= 3'd3;
  endfunction

  function automatic logic [1:0] bank_addr_bits(code3_t c);
    return c[1:0];
  endfunction

  function automatic logic [3:0] col_addr_bits(code3_t c);
    return 4'd8 + {2'b00, c[1:0]};
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(code3_t cl, code3_t bank, code3_t page);
    return {cl, 1'b0, 1'b0, bank, 1'b0, page};
  endfunction

endpackage

// File: rtl/sdcfg_access.sv
module sdcfg_access #(
  parameter int ADDR_W   = 8,
  parameter int BE_W     = 4,
  parameter int REG_ADDR = 8'h0C
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BE_W-1:0]   bus_be,
  input  logic              key_in,
  output logic              addr_hit,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic              cl_unlocked,
  output logic              touch
);
  import sdcfg_pkg::*;

  localparam logic [ADDR_W-1:0] MATCH = REG_ADDR[ADDR_W-1:0];
  localparam int HI_BYTE = KEY_BIT / 8;
  localparam int LO_BYTE = PAGE_LSB / 8;

  logic wr_acc;

  assign addr_hit    = (bus_addr == MATCH);
  assign wr_acc      = bus_we && addr_hit;
  assign wr_hi       = wr_acc && bus_be[HI_BYTE];
  assign wr_lo       = wr_acc && bus_be[LO_BYTE];
  assign cl_unlocked = wr_hi && key_in;
  assign touch       = wr_hi || wr_lo;

  logic unused_be;
  assign unused_be = ^bus_be;

endmodule

// File: rtl/sdcfg_fields.sv
module sdcfg_fields (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                cl_unlocked,
  input  sdcfg_pkg::code3_t   cl_in,
  input  sdcfg_pkg::code3_t   bank_in,
  input  sdcfg_pkg::code3_t   page_in,
  output sdcfg_pkg::code3_t   cl_q,
  output sdcfg_pkg::code3_t   bank_q,
  output sdcfg_pkg::code3_t   page_q,
  output sdcfg_pkg::code3_t   bank_nxt,
  output sdcfg_pkg::code3_t   page_nxt
);
  import sdcfg_pkg::*;

  code3_t cl_nxt;
  logic   cl_take, bank_take, page_take;

  assign cl_take   = cl_unlocked && cl_legal(cl_in);
  assign bank_take = wr_lo && bank_legal(bank_in);
  assign page_take = wr_lo && page_legal(page_in);

  assign cl_nxt   = cl_take   ? cl_in   : cl_q;
  assign bank_nxt = bank_take ? bank_in : bank_q;
  assign page_nxt = page_take ? page_in : page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q   <= CL_RST;
      bank_q <= BANK_RST;
      page_q <= PAGE_RST;
    end else begin
      cl_q   <= cl_nxt;
      bank_q <= bank_nxt;
      page_q <= page_nxt;
    end
  end

  a_r2_cl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_unlocked |=> $stable(cl_q));

  a_r7_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q == 3'd2) || (cl_q == 3'd3));

  a_r5_bank_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q <= 3'd2);

  a_r6_page_legal: assert property (@(posedge clk) disable iff (!rst_n)
    page_q <= 3'd3);

  a_r9_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> ($stable(bank_q) && $stable(page_q)));

endmodule

// File: rtl/sdcfg_widths.sv
module sdcfg_widths (
  input  logic              clk,
  input  logic              rst_n,
  input  sdcfg_pkg::code3_t bank_nxt,
  input  sdcfg_pkg::code3_t page_nxt,
  output logic [1:0]        bank_aw,
  output logic [3:0]        col_aw
);
  import sdcfg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_aw <= bank_addr_bits(BANK_RST);
      col_aw  <= col_addr_bits(PAGE_RST);
    end else begin
      bank_aw <= bank_addr_bits(bank_nxt);
      col_aw  <= col_addr_bits(page_nxt);
    end
  end

  a_r10_width_range: assert property (@(posedge clk) disable iff (!rst_n)
    (col_aw >= 4'd8) && (col_aw <= 4'd11) && (bank_aw <= 2'd2));

endmodule

// File: rtl/sdcfg_reg.sv
module sdcfg_reg #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_ADDR = 8'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2:0]          cas_lat,
  output logic [1:0]          bank_aw,
  output logic [3:0]          col_aw,
  output logic                init_req
);
  import sdcfg_pkg::*;

  localparam int BE_W = DATA_W / 8;

  logic   addr_hit, wr_hi, wr_lo, cl_unlocked, touch;
  code3_t cl_q, bank_q, page_q, bank_nxt, page_nxt;

  sdcfg_access #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .REG_ADDR(REG_ADDR)
  ) u_access (
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_be     (bus_be),
    .key_in     (bus_wdata[KEY_BIT]),
    .addr_hit   (addr_hit),
    .wr_hi      (wr_hi),
    .wr_lo      (wr_lo),
    .cl_unlocked(cl_unlocked),
    .touch      (touch)
  );

  sdcfg_fields u_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (wr_lo),
    .cl_unlocked(cl_unlocked),
    .cl_in      (bus_wdata[CL_LSB +: 3]),
    .bank_in    (bus_wdata[BANK_LSB +: 3]),
    .page_in    (bus_wdata[PAGE_LSB +: 3]),
    .cl_q       (cl_q),
    .bank_q     (bank_q),
    .page_q     (page_q),
    .bank_nxt   (bank_nxt),
    .page_nxt   (page_nxt)
  );

  sdcfg_widths u_widths (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank_nxt(bank_nxt),
    .page_nxt(page_nxt),
    .bank_aw (bank_aw),
    .col_aw  (col_aw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_req <= 1'b0;
    else        init_req <= touch;
  end

  assign cas_lat   = cl_q;
  assign bus_rdata = addr_hit ? {{(DATA_W-CFG_W){1'b0}}, pack_cfg(cl_q, bank_q, page_q)}
                              : '0;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:CFG_W], bus_wdata[7], bus_wdata[3]};

  // R8: any change of a decoded setting is accompanied by the request pulse
  a_r8_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cas_lat) || !$stable(bank_aw) || !$stable(col_aw)) |-> init_req);

  a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !addr_hit) |=> !init_req);

  a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[KEY_BIT]);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[7] && !bus_rdata[3] && (bus_rdata[DATA_W-1:CFG_W] == '0));

endmodule

// File: tb/sim_sdcfg_reg.sv
`timescale 1ns/1ps
module sim_sdcfg_reg;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int RA  = 8'h0C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_be = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [2:0]    cas_lat;
  logic [1:0]    bank_aw;
  logic [3:0]    col_aw;
  logic          init_req;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cl = 3, exp_bank = 2, exp_page = 1;

  always #2.5 clk = ~clk;

  sdcfg_reg #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cas_lat(cas_lat), .bank_aw(bank_aw), .col_aw(col_aw), .init_req(init_req)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_word();
    return (exp_cl << 9) | (exp_bank << 4) | exp_page;
  endfunction

  task automatic check_state(input string tag);
    chk(bus_rdata == DW'(exp_word()), tag, bus_rdata, exp_word());
    chk(int'(cas_lat) == exp_cl, tag, cas_lat, exp_cl);
    chk(int'(bank_aw) == exp_bank, tag, bank_aw, exp_bank);
    chk(int'(col_aw) == 8 + exp_page, tag, col_aw, 8 + exp_page);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [3:0] be,
                          input logic [DW-1:0] d, input string tag);
    logic hit, pulse;
    int c, b, p;
    hit   = (a == AW'(RA));
    pulse = hit && (be[0] || be[1]);
    c = int'(d[11:9]); b = int'(d[6:4]); p = int'(d[2:0]);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = AW'(RA);
    if (hit && be[1] && d[8] && (c == 2 || c == 3)) exp_cl = c;
    if (hit && be[0] && b <= 2) exp_bank = b;
    if (hit && be[0] && p <= 3) exp_page = p;
    #0.1;
    chk(init_req == pulse, {tag, " pulse"}, init_req, pulse);
    check_state(tag);
    @(negedge clk);
    chk(init_req == 1'b0, {tag, " R8 single"}, init_req, 0);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] bes [4];
    bes[0] = 4'b0011; bes[1] = 4'b0010; bes[2] = 4'b0001; bes[3] = 4'b1100;
    bus_addr = AW'(RA);
    repeat (3) @(negedge clk);
    chk(init_req == 1'b0, "R1 in reset", init_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rdata == 32'h621, "R1 reset word", bus_rdata, 32'h621);
    check_state("R1");
    @(negedge clk);
    chk(init_req == 1'b0, "R1 no pulse", init_req, 0);

    // CAS latency under every code, key state and byte-enable pattern
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 2; k++)
        for (int e = 0; e < 4; e++)
          do_write(AW'(RA), bes[e],
                   32'hABCD_0088 | (c << 9) | (k << 8) | (exp_bank << 4) | exp_page,
                   "R2/R3/R4/R7/R9 cl sweep");

    // bank and page under every code pair
    for (int b = 0; b < 8; b++)
      for (int p = 0; p < 8; p++)
        do_write(AW'(RA), 4'b0001, 32'h0000_0E00 | (b << 4) | p,
                 "R5/R6/R10 geometry sweep");

    // same value again still pulses
    do_write(AW'(RA), 4'b0011, DW'(exp_word()) | 32'h100, "R8 same value");

    // other address: no effect, reads zero
    do_write(AW'(RA + 1), 4'b1111, 32'h0000_0500, "R11 miss write");
    @(negedge clk);
    bus_addr = AW'(RA + 4);
    #0.1;
    chk(bus_rdata == '0, "R11 miss read", bus_rdata, 0);
    bus_addr = AW'(RA);

    // key bit with low byte only: CL must stay
    do_write(AW'(RA), 4'b0001, 32'h0000_0500, "R2 key without hi byte");
    do_write(AW'(RA), 4'b0010, 32'h0000_0700, "R2 unlocked cl 3");
    do_write(AW'(RA), 4'b0010, 32'h0000_0500, "R2 unlocked cl 2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule